// File: doc/BRIEF.md
# SPI Flash Block-Lock Protection Controller

This block is the write-protection slice of a serial flash slave. It watches an SPI mode-0 link with one data line in each direction. While chip select is low it shifts in an opcode and any address or data bytes on `si`. It keeps one protect bit for each 64 KB block of a 16 MB array, which gives 256 bits. It answers a per-block status query on `so` and can protect or release every block with a single command. The program and erase engine of the surrounding flash reads `lock_map` to decide whether a block may be altered.

The link pins are sampled with the block's own `clk`, which must run well above the serial clock. The pins pass through a synchronizer. Every state-changing command executes on the rising edge of chip select, and only when the number of bits clocked in matches the command length exactly. The gang commands also require the write-enable latch and the per-block protection mode. A command that fails any of these conditions, or an opcode the block does not know, changes no state. The same slice holds the clear command for the program/erase fail flag and a 4-bit output-drive setting that the pad logic consumes.

Top module: `spi_lock_ctrl`

## Requirements
- R1: After reset all protect bits are 0, `wel`, `prot_mode` and `pe_fail` are 0, `drv_src` and `drv_snk` are 0, and `so_oe` is 0.
- R2: The 8-bit command 0x06 sets `wel`.
- R3: The 8-bit command 0x68 sets `prot_mode`. It stays set until reset.
- R4: With `prot_mode` set, command 0x3C followed by three address bytes (most significant bit first) selects the block given by address bits [23:16]. Starting at the falling SCLK edge after the 32nd bit, `so` drives the status byte MSB first. Bits [7:1] are 0 and bit 0 is the protect bit, where 1 means protected. The byte repeats while chip select stays low, and `so_oe` is 1 throughout.
- R5: With `prot_mode` clear, command 0x3C never raises `so_oe`.
- R6: The 8-bit command 0x7E sets every protect bit and clears `wel`. It does so only when `wel` and `prot_mode` are both 1.
- R7: The 8-bit command 0x98 clears every protect bit and clears `wel`, under the same conditions as R6.
- R8: A gang command (0x7E or 0x98) issued while `wel` or `prot_mode` is 0 leaves the protect bits and `wel` unchanged.
- R9: Commands 0x06, 0x68, 0x7E, 0x98 and 0x30 need exactly 8 bits, and 0x61 needs exactly 16 bits. If chip select rises after any other bit count, the command is discarded.
- R10: A one-cycle pulse on `pe_fail_set` sets `pe_fail`. The 8-bit command 0x30 clears it. If both occur in the same cycle, the set wins.
- R11: Command 0x61 followed by one data byte loads `drv_src` from data bits [3:2] and `drv_snk` from data bits [1:0]. Data bits [7:4] are ignored.
- R12: An opcode outside the set listed above changes no state.
- R13: Once chip select is high, `so_oe` is 0. At most 4 `clk` cycles may pass after `cs_n` rises before it drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low (mode 0) |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in, sampled on rising SCLK |
| so | output | 1 | Serial data out, updated after falling SCLK |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| pe_fail_set | input | 1 | Pulse from the program/erase engine that sets the fail flag |
| pe_fail | output | 1 | Program/erase fail flag |
| wel | output | 1 | Write-enable latch |
| prot_mode | output | 1 | Per-block protection mode selected |
| drv_src | output | 2 | Source (pull-up) drive-strength option |
| drv_snk | output | 2 | Sink (pull-down) drive-strength option |
| lock_map | output | 256 | Protect bit of each 64 KB block |

## Verification
The serial pins pass through two synchronizer flops and one edge register. As a result, a command's register update lands 3 `clk` cycles after `cs_n` rises, and a new `so` bit appears 3 to 4 cycles after SCLK falls. The bench holds each SCLK phase for 8 cycles and samples `so` and `so_oe` in the last cycle of the low phase, just before the rising edge that a real master would use. After raising chip select it waits 12 cycles before it reads any register port. Every sample therefore falls well after the result is due and before the next stimulus.

// File: rtl/spi_lock_pkg.sv
package spi_lock_pkg;

   localparam int unsigned OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_WREN   = 8'h06;
   localparam logic [OPC_W-1:0] OPC_PMODE  = 8'h68;
   localparam logic [OPC_W-1:0] OPC_RDSTAT = 8'h3C;
   localparam logic [OPC_W-1:0] OPC_GLOCK  = 8'h7E;
   localparam logic [OPC_W-1:0] OPC_GFREE  = 8'h98;
   localparam logic [OPC_W-1:0] OPC_FCLR   = 8'h30;
   localparam logic [OPC_W-1:0] OPC_DRVCFG = 8'h61;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WREN,
      CMD_PMODE,
      CMD_RDSTAT,
      CMD_GLOCK,
      CMD_GFREE,
      CMD_FCLR,
      CMD_DRVCFG
   } cmd_e;

   typedef struct packed {
      logic [1:0] src;
      logic [1:0] snk;
   } drv_cfg_t;

   function automatic cmd_e decode_opc(input logic [OPC_W-1:0] opc);
      cmd_e c;
      case (opc)
         OPC_WREN:   c = CMD_WREN;
         OPC_PMODE:  c = CMD_PMODE;
         OPC_RDSTAT: c = CMD_RDSTAT;
         OPC_GLOCK:  c = CMD_GLOCK;
         OPC_GFREE:  c = CMD_GFREE;
         OPC_FCLR:   c = CMD_FCLR;
         OPC_DRVCFG: c = CMD_DRVCFG;
         default:    c = CMD_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/spi_lock_front.sv
// Pin synchronizer and edge detector for the serial link.
module spi_lock_front #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic si,
   output logic sel,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_done,
   output logic si_s
);

   localparam int unsigned PIN_N   = 3;
   localparam int unsigned P_SCLK  = 2;
   localparam int unsigned P_CS    = 1;
   localparam int unsigned P_SI    = 0;
   localparam logic [PIN_N-1:0] PIN_IDLE = 3'b010;

   logic [SYNC_STAGES-1:0][PIN_N-1:0] chain_q;
   logic [PIN_N-1:0]                  raw;
   logic [PIN_N-1:0]                  stage_last;
   logic                              sclk_q;
   logic                              cs_q;

   assign raw        = {sclk, cs_n, si};
   assign stage_last = chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {SYNC_STAGES{PIN_IDLE}};
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], raw};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= stage_last[P_SCLK];
         cs_q   <= stage_last[P_CS];
      end
   end

   assign sel       = ~stage_last[P_CS];
   assign si_s      = stage_last[P_SI];
   assign sclk_rise = sel &  stage_last[P_SCLK] & ~sclk_q;
   assign sclk_fall = sel & ~stage_last[P_SCLK] &  sclk_q;
   assign cs_done   = stage_last[P_CS] & ~cs_q;

endmodule

// File: rtl/spi_lock_shift.sv
// Bit counter, opcode and address/data shift registers for one selection.
module spi_lock_shift #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned BLK_W  = 8,
   parameter int unsigned CNT_W  = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              sel,
   input  logic                              sclk_rise,
   input  logic                              si_s,
   output logic [CNT_W-1:0]                  bit_cnt,
   output logic [spi_lock_pkg::OPC_W-1:0]    opcode,
   output logic [BLK_W-1:0]                  blk_idx,
   output logic [3:0]                        cfg_nib
);

   localparam int unsigned OW = spi_lock_pkg::OPC_W;
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] OPC_END  = CNT_W'(OW);
   localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(OW + ADDR_W);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         opcode  <= '0;
         addr_q  <= '0;
      end else if (!sel) begin
         bit_cnt <= '0;
         opcode  <= '0;
         addr_q  <= '0;
      end else if (sclk_rise) begin
         if (bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (bit_cnt < OPC_END) begin
            opcode <= {opcode[OW-2:0], si_s};
         end else if (bit_cnt < ADDR_END) begin
            addr_q <= {addr_q[ADDR_W-2:0], si_s};
         end
      end
   end

   assign blk_idx = addr_q[ADDR_W-1 -: BLK_W];
   assign cfg_nib = addr_q[3:0];

endmodule

// File: rtl/spi_lock_bank.sv
// One protect bit per block, all set or cleared together.
module spi_lock_bank #(
   parameter int unsigned BLK_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set_all,
   input  logic                    clr_all,
   input  logic [BLK_W-1:0]        idx,
   output logic [(1<<BLK_W)-1:0]   map,
   output logic                    bit_at_idx
);

   localparam int unsigned NBLK = 1 << BLK_W;

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map[b] <= 1'b0;
         end else if (set_all) begin
            map[b] <= 1'b1;
         end else if (clr_all) begin
            map[b] <= 1'b0;
         end
      end
   end

   assign bit_at_idx = map[idx];

endmodule

// File: rtl/spi_lock_ctrl.sv
// Block-protection command slice of a serial flash slave.
module spi_lock_ctrl #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned BLK_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sclk,
   input  logic                    cs_n,
   input  logic                    si,
   output logic                    so,
   output logic                    so_oe,
   input  logic                    pe_fail_set,
   output logic                    pe_fail,
   output logic                    wel,
   output logic                    prot_mode,
   output logic [1:0]              drv_src,
   output logic [1:0]              drv_snk,
   output logic [(1<<BLK_W)-1:0]   lock_map
);

   import spi_lock_pkg::*;

   localparam int unsigned NBLK      = 1 << BLK_W;
   localparam int unsigned STAT_BITS = 8;
   localparam int unsigned POS_W     = $clog2(STAT_BITS);
   localparam logic [CNT_W-1:0] LEN_ONE  = CNT_W'(OPC_W);
   localparam logic [CNT_W-1:0] LEN_TWO  = CNT_W'(2 * OPC_W);
   localparam logic [CNT_W-1:0] RD_START = CNT_W'(OPC_W + ADDR_W);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(STAT_BITS - 1);

   if (BLK_W < 1 || BLK_W > ADDR_W) begin : g_bad_blk
      $error("BLK_W must lie in 1..ADDR_W");
   end
   if (ADDR_W % 8 != 0 || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be a whole number of bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((1 << CNT_W) - 1 < OPC_W + ADDR_W + STAT_BITS) begin : g_bad_cnt
      $error("CNT_W too narrow for the longest command");
   end
   if (NBLK > 4096) begin : g_bad_nblk
      $error("BLK_W gives too many protect bits");
   end

   logic                 sel;
   logic                 sclk_rise;
   logic                 sclk_fall;
   logic                 cs_done;
   logic                 si_s;
   logic [CNT_W-1:0]     bit_cnt;
   logic [OPC_W-1:0]     opcode;
   logic [BLK_W-1:0]     blk_idx;
   logic [3:0]           cfg_nib;
   logic                 lock_bit;

   spi_lock_front #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .si       (si),
      .sel      (sel),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .cs_done  (cs_done),
      .si_s     (si_s)
   );

   spi_lock_shift #(
      .ADDR_W(ADDR_W),
      .BLK_W (BLK_W),
      .CNT_W (CNT_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .sclk_rise(sclk_rise),
      .si_s     (si_s),
      .bit_cnt  (bit_cnt),
      .opcode   (opcode),
      .blk_idx  (blk_idx),
      .cfg_nib  (cfg_nib)
   );

   // Command qualification at the end of a selection
   cmd_e cmd;
   logic len_one;
   logic len_two;
   logic gang_ok;
   logic do_wren;
   logic do_pmode;
   logic gang_set;
   logic gang_clr;
   logic do_fclr;
   logic do_drv;

   assign cmd      = decode_opc(opcode);
   assign len_one  = (bit_cnt == LEN_ONE);
   assign len_two  = (bit_cnt == LEN_TWO);
   assign gang_ok  = wel & prot_mode;
   assign do_wren  = cs_done & len_one & (cmd == CMD_WREN);
   assign do_pmode = cs_done & len_one & (cmd == CMD_PMODE);
   assign gang_set = cs_done & len_one & (cmd == CMD_GLOCK) & gang_ok;
   assign gang_clr = cs_done & len_one & (cmd == CMD_GFREE) & gang_ok;
   assign do_fclr  = cs_done & len_one & (cmd == CMD_FCLR);
   assign do_drv   = cs_done & len_two & (cmd == CMD_DRVCFG);

   spi_lock_bank #(
      .BLK_W(BLK_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_all   (gang_set),
      .clr_all   (gang_clr),
      .idx       (blk_idx),
      .map       (lock_map),
      .bit_at_idx(lock_bit)
   );

   // Latches and configuration
   drv_cfg_t drv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel       <= 1'b0;
         prot_mode <= 1'b0;
         pe_fail   <= 1'b0;
         drv_q     <= '0;
      end else begin
         if (gang_set || gang_clr) begin
            wel <= 1'b0;
         end else if (do_wren) begin
            wel <= 1'b1;
         end
         if (do_pmode) begin
            prot_mode <= 1'b1;
         end
         if (pe_fail_set) begin
            pe_fail <= 1'b1;
         end else if (do_fclr) begin
            pe_fail <= 1'b0;
         end
         if (do_drv) begin
            drv_q <= drv_cfg_t'(cfg_nib);
         end
      end
   end

   assign drv_src = drv_q.src;
   assign drv_snk = drv_q.snk;

   // Status read-out, shifted on falling SCLK
   logic             rd_live;
   logic [POS_W-1:0] rd_pos;

   assign rd_live = sel & prot_mode & (cmd == CMD_RDSTAT) & (bit_cnt >= RD_START);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so     <= 1'b0;
         so_oe  <= 1'b0;
         rd_pos <= '0;
      end else if (!sel) begin
         so     <= 1'b0;
         so_oe  <= 1'b0;
         rd_pos <= '0;
      end else if (sclk_fall && rd_live) begin
         so_oe  <= 1'b1;
         so     <= (rd_pos == LAST_POS) ? lock_bit : 1'b0;
         rd_pos <= rd_pos + 1'b1;
      end
   end

endmodule

// File: rtl/spi_lock_ctrl_chk.sv
module spi_lock_ctrl_chk #(
   parameter int unsigned NBLK = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sel,
   input logic            cs_done,
   input logic            gang_set,
   input logic            gang_clr,
   input logic            wel,
   input logic            prot_mode,
   input logic            so_oe,
   input logic            pe_fail_set,
   input logic            pe_fail,
   input logic [1:0]      drv_src,
   input logic [1:0]      drv_snk,
   input logic [NBLK-1:0] lock_map
);

   // R6
   glock_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gang_set |=> (&lock_map));

   // R7
   gfree_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gang_clr |=> (lock_map == '0));

   // R8
   wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel) |-> $past(gang_set | gang_clr));

   // R9
   lock_map_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_map) |-> $past(cs_done));

   // R11
   drv_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({drv_src, drv_snk}) |-> $past(cs_done));

   // R3
   pmode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prot_mode |=> prot_mode);

   // R5
   so_oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_oe) |-> prot_mode);

   // R10
   fail_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pe_fail_set |=> pe_fail);

   // R13
   so_oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !so_oe);

endmodule

bind spi_lock_ctrl spi_lock_ctrl_chk #(
   .NBLK(1 << BLK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel        (sel),
   .cs_done    (cs_done),
   .gang_set   (gang_set),
   .gang_clr   (gang_clr),
   .wel        (wel),
   .prot_mode  (prot_mode),
   .so_oe      (so_oe),
   .pe_fail_set(pe_fail_set),
   .pe_fail    (pe_fail),
   .drv_src    (drv_src),
   .drv_snk    (drv_snk),
   .lock_map   (lock_map)
);

// File: tb/spi_lock_ctrl_bench.sv
`timescale 1ns/1ps
module spi_lock_ctrl_bench;

   localparam int NBLK  = 256;
   localparam int HALF  = 8;
   localparam int SETTLE = 12;
   localparam int LIMIT = 150000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sclk = 1'b0;
   logic            cs_n = 1'b1;
   logic            si = 1'b0;
   logic            pe_fail_set = 1'b0;
   logic            so;
   logic            so_oe;
   logic            pe_fail;
   logic            wel;
   logic            prot_mode;
   logic [1:0]      drv_src;
   logic [1:0]      drv_snk;
   logic [NBLK-1:0] lock_map;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   spi_lock_ctrl u_spi_lock_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (sclk),
      .cs_n       (cs_n),
      .si         (si),
      .so         (so),
      .so_oe      (so_oe),
      .pe_fail_set(pe_fail_set),
      .pe_fail    (pe_fail),
      .wel        (wel),
      .prot_mode  (prot_mode),
      .drv_src    (drv_src),
      .drv_snk    (drv_snk),
      .lock_map   (lock_map)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == LIMIT) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests = tests + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer_bit(input logic b, output logic so_b, output logic oe_b);
      si = b;
      wait_clk(HALF);
      so_b = so;
      oe_b = so_oe;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
   endtask

   task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] oe);
      for (int i = 7; i >= 0; i--) begin
         xfer_bit(tx[i], rx[i], oe[i]);
      end
   endtask

   task automatic sel_lo();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic sel_hi();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(SETTLE);
   endtask

   // Sends nbits of word, MSB first, in one selection
   task automatic send_bits(input logic [15:0] word, input int nbits);
      logic d0, d1;
      sel_lo();
      for (int i = nbits - 1; i >= 0; i--) begin
         xfer_bit(word[i], d0, d1);
      end
      sel_hi();
   endtask

   task automatic send_op(input logic [7:0] op);
      send_bits({8'h00, op}, 8);
   endtask

   // Status query; returns two read-out bytes and their enable bits
   task automatic query(input logic [23:0] a, output logic [15:0] rx, output logic [15:0] oe,
                        output logic [31:0] oe_hdr);
      logic [7:0] r, e;
      sel_lo();
      xfer_byte(8'h3C, r, e);     oe_hdr[31:24] = e;
      xfer_byte(a[23:16], r, e);  oe_hdr[23:16] = e;
      xfer_byte(a[15:8], r, e);   oe_hdr[15:8]  = e;
      xfer_byte(a[7:0], r, e);    oe_hdr[7:0]   = e;
      xfer_byte(8'h00, rx[15:8], oe[15:8]);
      xfer_byte(8'h00, rx[7:0], oe[7:0]);
      sel_hi();
   endtask

   task automatic read_lock(input logic [23:0] a, input logic exp_bit, input string req);
      logic [15:0] rx, oe;
      logic [31:0] hdr;
      query(a, rx, oe, hdr);
      chk({req, " status byte repeated"}, rx, {2{7'b0, exp_bit}});
      chk({req, " so_oe during read-out"}, oe, 16'hFFFF);
      chk({req, " so_oe during header"}, hdr, 32'h0);
      chk("R13 so_oe after deselect", so_oe, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 wel", wel, 1'b0);
      chk("R1 prot_mode", prot_mode, 1'b0);
      chk("R1 pe_fail", pe_fail, 1'b0);
      chk("R1 drive config", {drv_src, drv_snk}, 4'h0);
      chk("R1 so_oe", so_oe, 1'b0);
      chk("R1 lock map", lock_map, '0);
   endtask

   task automatic t_read_no_mode();
      logic [15:0] rx, oe;
      logic [31:0] hdr;
      query(24'h05_0000, rx, oe, hdr);
      chk("R5 so_oe read-out without mode", oe, 16'h0);
      chk("R5 so_oe header without mode", hdr, 32'h0);
   endtask

   task automatic t_wren_and_gang_no_mode();
      send_bits(16'h0006, 7);
      chk("R9 short write enable", wel, 1'b0);
      send_op(8'h06);
      chk("R2 write enable", wel, 1'b1);
      send_op(8'h7E);
      chk("R8 gang lock without mode map", lock_map, '0);
      chk("R8 gang lock without mode wel", wel, 1'b1);
   endtask

   task automatic t_mode_and_lock();
      send_bits(16'h6800, 16);
      chk("R9 long mode select", prot_mode, 1'b0);
      send_op(8'h68);
      chk("R3 mode select", prot_mode, 1'b1);
      send_op(8'h7E);
      chk("R6 gang lock map", lock_map, {NBLK{1'b1}});
      chk("R6 gang lock clears wel", wel, 1'b0);
      read_lock(24'h12_3456, 1'b1, "R4 locked block");
      read_lock(24'hFF_FFFF, 1'b1, "R4 top block");
   endtask

   task automatic t_unlock();
      send_op(8'h98);
      chk("R8 gang unlock without wel", lock_map, {NBLK{1'b1}});
      send_op(8'h06);
      send_bits(16'h04C7, 11);
      chk("R9 gang unlock 11 bits map", lock_map, {NBLK{1'b1}});
      chk("R9 gang unlock 11 bits wel", wel, 1'b1);
      send_bits(16'h9800, 16);
      chk("R9 gang unlock 16 bits map", lock_map, {NBLK{1'b1}});
      send_op(8'h98);
      chk("R7 gang unlock map", lock_map, '0);
      chk("R7 gang unlock clears wel", wel, 1'b0);
      read_lock(24'h00_0000, 1'b0, "R4 free block");
      chk("R3 mode persists", prot_mode, 1'b1);
   endtask

   task automatic t_fail_flag();
      pe_fail_set = 1'b1;
      wait_clk(1);
      pe_fail_set = 1'b0;
      wait_clk(2);
      chk("R10 fail set", pe_fail, 1'b1);
      send_bits(16'h0300, 12);
      chk("R9 fail clear 12 bits", pe_fail, 1'b1);
      send_op(8'h30);
      chk("R10 fail clear", pe_fail, 1'b0);
   endtask

   task automatic t_drive();
      send_bits(16'h61A9, 16);
      chk("R11 drive config A9", {drv_src, drv_snk}, {2'b10, 2'b01});
      send_bits(16'h61F6, 16);
      chk("R11 drive config upper ignored", {drv_src, drv_snk}, {2'b01, 2'b10});
      send_bits(16'h0613, 12);
      chk("R9 drive config 12 bits", {drv_src, drv_snk}, {2'b01, 2'b10});
      send_op(8'h61);
      chk("R9 drive config 8 bits", {drv_src, drv_snk}, {2'b01, 2'b10});
   endtask

   task automatic t_unknown();
      send_op(8'h06);
      send_op(8'h5A);
      send_op(8'hFF);
      send_bits(16'h0000, 16);
      chk("R12 unknown keeps wel", wel, 1'b1);
      chk("R12 unknown keeps map", lock_map, '0);
      chk("R12 unknown keeps drive", {drv_src, drv_snk}, {2'b01, 2'b10});
      chk("R12 unknown keeps fail", pe_fail, 1'b0);
   endtask

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_read_no_mode();
      t_wren_and_gang_no_mode();
      t_mode_and_lock();
      t_unlock();
      t_fail_flag();
      t_drive();
      t_unknown();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule